// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block serves a five-stage integer pipeline: fetch, decode with register read, execute, memory and write-back. Every instruction passes through all five stages. Register operands are read only in decode and results are written only in write-back, so the only dependence that can go wrong is a read that comes after a write. The block watches each instruction as it leaves decode. It follows that instruction's destination specifier down the execute, memory and write-back pipeline registers. For the instruction in execute, it drives the select lines of the two ALU operand multiplexers. Each operand is taken from the register file read, from the execute/memory pipeline register, or from the memory/write-back pipeline register.

A load returns its data only at the end of the memory stage. If the instruction right behind a load reads the load's destination, no bypass path can deliver the value in time. The block detects that case while the consumer is still in decode. It raises a stall that freezes the PC and the fetch/decode register. It also raises a bubble that loads an empty operation, with every write enable cleared, into the decode/execute register. One cycle later the load has reached the memory stage and the consumer may proceed. The consumer then takes the loaded value from the memory/write-back bypass. Register 0 reads as zero and never takes part in forwarding or interlocking. The register file is assumed to write in the first half of the cycle, so a producer three instructions ahead needs no bypass at all.

Top module: `fwd_hazard_unit`

## Requirements
- R1: Each operand select uses the encoding 2'b00 = register file, 2'b10 = execute/memory bypass, 2'b01 = memory/write-back bypass. A used, non-zero source equal to the destination of a writing instruction one position ahead selects 2'b10. The value 2'b11 never appears.
- R2: A used, non-zero source that matches only the destination of a writing instruction two positions ahead selects 2'b01.
- R3: When the instructions both one and two positions ahead write the matching register, the select is 2'b10, so the younger result wins.
- R4: A source or destination of register 0 never produces a non-zero select and never produces a stall.
- R5: A producer three or more positions ahead causes no forwarding (select 2'b00), because the register file already holds its result.
- R6: An instruction in decode whose used source matches the non-zero destination of a load in execute raises the stall in that same cycle. The stall lasts exactly one cycle while decode is held. When the consumer then enters execute, its select for that operand is 2'b01.
- R7: A source marked as not used never causes forwarding or a stall, even when its specifier matches.
- R8: A decode slot with the valid flag low never stalls. When it moves down the pipeline it is never a forwarding source.
- R9: A synchronous active-low reset empties all tracked stages. On the first cycle after reset, both selects are 2'b00 and the stall is low.
- R10: The bubble output is high in exactly the cycles in which the stall output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs1 | input | 5 | First source specifier of the decode instruction |
| id_rs1_used | input | 1 | First source is actually read |
| id_rs2 | input | 5 | Second source specifier of the decode instruction |
| id_rs2_used | input | 1 | Second source is actually read |
| id_rd | input | 5 | Destination specifier of the decode instruction |
| id_we | input | 1 | Decode instruction writes its destination |
| id_load | input | 1 | Decode instruction is a load |
| fwd_a_sel | output | 2 | Select for the first ALU operand multiplexer |
| fwd_b_sel | output | 2 | Select for the second ALU operand multiplexer |
| stall_front | output | 1 | Hold the PC and the fetch/decode register |
| bubble_ex | output | 1 | Load an empty operation into the decode/execute register |

## Verification
The hardest situation to reach from the ports is the one just after a load-use interlock. In that cycle the empty operation sits in execute, the load sits in memory, and the held consumer must pick up the load result through the memory/write-back bypass one cycle later. The stimulus table repeats the held consumer exactly as the upstream stages would during the freeze. It does this once for a dependence on each operand, so the bench sees the bubble in execute and then the 2'b01 select. Directed steps after the table place a load in execute next to an invalid decode slot, and they apply reset while a load-use stall is pending.

// File: rtl/fwd_pkg.sv
// Shared definitions for the forwarding and interlock unit.
// Assumes a two-source, one-destination instruction format.
package fwd_pkg;

    // Number of ALU operands that each get a bypass multiplexer.
    localparam int NUM_SRC = 2;

    // Operand multiplexer select encoding.
    typedef enum logic [1:0] {
        FS_REGFILE = 2'b00,
        FS_MEMWB   = 2'b01,
        FS_EXMEM   = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/fwd_stage_track.sv
// Follows each instruction's specifiers from decode through write-back.
// Assumes the decode inputs are stable for the whole cycle and that the
// surrounding pipeline advances every cycle except where it is frozen.
// A bubble replaces the entering instruction with an empty operation.
module fwd_stage_track #(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic              id_rs1_used,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_rs2_used,
    input  logic [REG_AW-1:0] id_rd,
    input  logic              id_we,
    input  logic              id_load,
    input  logic              bubble,
    output logic [REG_AW-1:0] ex_rs1,
    output logic              ex_rs1_used,
    output logic [REG_AW-1:0] ex_rs2,
    output logic              ex_rs2_used,
    output logic [REG_AW-1:0] ex_rd,
    output logic              ex_we,
    output logic              ex_load,
    output logic [REG_AW-1:0] mem_rd,
    output logic              mem_we,
    output logic [REG_AW-1:0] wb_rd,
    output logic              wb_we
);

    typedef struct packed {
        logic [REG_AW-1:0] rs1;
        logic              u1;
        logic [REG_AW-1:0] rs2;
        logic              u2;
        logic [REG_AW-1:0] rd;
        logic              we;
        logic              ld;
    } ex_slot_t;

    ex_slot_t          ex_q;
    logic [REG_AW-1:0] mem_rd_q, wb_rd_q;
    logic              mem_we_q, wb_we_q;

    // Decode/execute shadow: capture decode fields, or an empty op on a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n || bubble) begin
            ex_q <= '0;
        end else begin
            ex_q.rs1 <= id_rs1;
            ex_q.u1  <= id_valid & id_rs1_used;
            ex_q.rs2 <= id_rs2;
            ex_q.u2  <= id_valid & id_rs2_used;
            ex_q.rd  <= id_rd;
            ex_q.we  <= id_valid & id_we;
            ex_q.ld  <= id_valid & id_load;
        end
    end

    // Execute/memory and memory/write-back shadows: destination only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_q <= '0;
            mem_we_q <= 1'b0;
            wb_rd_q  <= '0;
            wb_we_q  <= 1'b0;
        end else begin
            mem_rd_q <= ex_q.rd;
            mem_we_q <= ex_q.we;
            wb_rd_q  <= mem_rd_q;
            wb_we_q  <= mem_we_q;
        end
    end

    assign ex_rs1      = ex_q.rs1;
    assign ex_rs1_used = ex_q.u1;
    assign ex_rs2      = ex_q.rs2;
    assign ex_rs2_used = ex_q.u2;
    assign ex_rd       = ex_q.rd;
    assign ex_we       = ex_q.we;
    assign ex_load     = ex_q.ld;
    assign mem_rd      = mem_rd_q;
    assign mem_we      = mem_we_q;
    assign wb_rd       = wb_rd_q;
    assign wb_we       = wb_we_q;

endmodule

// File: rtl/fwd_operand_sel.sv
// Chooses the bypass source for one ALU operand of the execute instruction.
// Assumes register 0 is hardwired to zero and so is never bypassed.
// The younger producer (execute/memory) has priority over the older one.
module fwd_operand_sel #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic              src_used,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    output logic [1:0]        sel
);
    import fwd_pkg::*;

    fwd_sel_e sel_e;

    // Priority compare of the source against the two older destinations.
    always_comb begin
        sel_e = FS_REGFILE;
        if (src_used && (src != '0)) begin
            if (mem_we && (mem_rd == src)) begin
                sel_e = FS_EXMEM;
            end else if (wb_we && (wb_rd == src)) begin
                sel_e = FS_MEMWB;
            end
        end
    end

    assign sel = sel_e;

endmodule

// File: rtl/fwd_loaduse_detect.sv
// Detects a decode instruction that needs the result of a load now in execute.
// Assumes load data is available only after the memory stage, so one
// bubble is enough. Register 0 and unused sources never interlock.
module fwd_loaduse_detect #(
    parameter int REG_AW = 5
) (
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic              id_rs1_used,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_rs2_used,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_we,
    input  logic              ex_load,
    output logic              hazard
);

    logic load_pending;
    logic hit1, hit2;

    // Compare both decode sources against the pending load destination.
    always_comb begin
        load_pending = ex_load && ex_we && (ex_rd != '0);
        hit1         = id_rs1_used && (id_rs1 == ex_rd);
        hit2         = id_rs2_used && (id_rs2 == ex_rd);
        hazard       = id_valid && load_pending && (hit1 || hit2);
    end

endmodule

// File: rtl/fwd_hazard_unit.sv
// Top of the forwarding and interlock unit for a five-stage pipeline.
// Assumes reads in decode, writes in write-back, and a register file that
// writes before it reads in the same cycle. It drives the two ALU
// bypass selects and the load-use stall and bubble.
module fwd_hazard_unit #(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic              id_rs1_used,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_rs2_used,
    input  logic [REG_AW-1:0] id_rd,
    input  logic              id_we,
    input  logic              id_load,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic              stall_front,
    output logic              bubble_ex
);
    import fwd_pkg::*;

    logic [REG_AW-1:0] ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic              ex_rs1_used, ex_rs2_used, ex_we, ex_load;
    logic              mem_we, wb_we;
    logic              load_use;

    logic [REG_AW-1:0] ex_src  [NUM_SRC];
    logic              ex_used [NUM_SRC];
    logic [1:0]        sel     [NUM_SRC];

    fwd_stage_track #(.REG_AW(REG_AW)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_valid    (id_valid),
        .id_rs1      (id_rs1),
        .id_rs1_used (id_rs1_used),
        .id_rs2      (id_rs2),
        .id_rs2_used (id_rs2_used),
        .id_rd       (id_rd),
        .id_we       (id_we),
        .id_load     (id_load),
        .bubble      (load_use),
        .ex_rs1      (ex_rs1),
        .ex_rs1_used (ex_rs1_used),
        .ex_rs2      (ex_rs2),
        .ex_rs2_used (ex_rs2_used),
        .ex_rd       (ex_rd),
        .ex_we       (ex_we),
        .ex_load     (ex_load),
        .mem_rd      (mem_rd),
        .mem_we      (mem_we),
        .wb_rd       (wb_rd),
        .wb_we       (wb_we)
    );

    assign ex_src[0]  = ex_rs1;
    assign ex_src[1]  = ex_rs2;
    assign ex_used[0] = ex_rs1_used;
    assign ex_used[1] = ex_rs2_used;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
        fwd_operand_sel #(.REG_AW(REG_AW)) u_sel (
            .src      (ex_src[g]),
            .src_used (ex_used[g]),
            .mem_rd   (mem_rd),
            .mem_we   (mem_we),
            .wb_rd    (wb_rd),
            .wb_we    (wb_we),
            .sel      (sel[g])
        );
    end

    fwd_loaduse_detect #(.REG_AW(REG_AW)) u_detect (
        .id_valid    (id_valid),
        .id_rs1      (id_rs1),
        .id_rs1_used (id_rs1_used),
        .id_rs2      (id_rs2),
        .id_rs2_used (id_rs2_used),
        .ex_rd       (ex_rd),
        .ex_we       (ex_we),
        .ex_load     (ex_load),
        .hazard      (load_use)
    );

    assign fwd_a_sel   = sel[0];
    assign fwd_b_sel   = sel[1];
    assign stall_front = load_use;
    assign bubble_ex   = load_use;

endmodule

// File: rtl/fwd_hazard_chk.sv
// Checker for the forwarding and interlock unit, bound to its top.
// Relates the decode inputs to the stall and select outputs over time.
module fwd_hazard_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              id_valid,
    input logic [REG_AW-1:0] id_rs1,
    input logic              id_rs1_used,
    input logic [REG_AW-1:0] id_rs2,
    input logic              id_rs2_used,
    input logic [1:0]        fwd_a_sel,
    input logic [1:0]        fwd_b_sel,
    input logic              stall_front,
    input logic              bubble_ex
);

    // R1: the unused select code never appears
    p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11));

    // R4: sources of register 0 never interlock
    p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs1 == '0 && id_rs2 == '0) |-> !stall_front);

    // R6: a load-use stall lasts one cycle
    p_single_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_front |=> !stall_front);

    // R10: the cycle after a bubble never stalls again
    p_bubble_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_ex |=> !bubble_ex && !stall_front);

    // R7: unused sources never interlock
    p_unused_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_rs1_used && !id_rs2_used) |-> !stall_front);

    // R8: an invalid decode slot never interlocks
    p_invalid_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !stall_front);

    // R9: after a reset edge nothing is forwarded and nothing stalls
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00 && !stall_front));

endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.REG_AW(REG_AW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_valid    (id_valid),
    .id_rs1      (id_rs1),
    .id_rs1_used (id_rs1_used),
    .id_rs2      (id_rs2),
    .id_rs2_used (id_rs2_used),
    .fwd_a_sel   (fwd_a_sel),
    .fwd_b_sel   (fwd_b_sel),
    .stall_front (stall_front),
    .bubble_ex   (bubble_ex)
);

// File: tb/test_fwd_hazard_unit.sv
// Bench for the forwarding and interlock unit. Each table row is the
// instruction in decode for one cycle. Its expected selects belong to
// the instruction in execute, and its expected stall to the decode slot.
module test_fwd_hazard_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       id_valid, id_rs1_used, id_rs2_used, id_we, id_load;
    logic [4:0] id_rs1, id_rs2, id_rd;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic       stall_front, bubble_ex;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    fwd_hazard_unit i_fwd_hazard_unit (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid),
        .id_rs1(id_rs1), .id_rs1_used(id_rs1_used),
        .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
        .id_rd(id_rd), .id_we(id_we), .id_load(id_load),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .stall_front(stall_front), .bubble_ex(bubble_ex)
    );

    typedef struct packed {
        logic       v;
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic       u1;
        logic       u2;
        logic [4:0] rd;
        logic       we;
        logic       ld;
        logic [1:0] ea;
        logic [1:0] eb;
        logic       es;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 28;
    // Fields: v, rs1, rs2, u1, u2, rd, we, ld, exp_a, exp_b, exp_stall, req
    localparam vec_t VEC [NV] = '{
        '{1, 2, 3, 1,1, 1, 1,0, 0,0,0, 9},   // R9: first instr after reset
        '{1, 1, 3, 1,1, 4, 1,0, 0,0,0, 1},
        '{1, 1, 7, 1,1, 6, 1,0, 2,0,0, 1},   // R1: distance 1
        '{1, 1, 9, 1,1, 8, 1,0, 1,0,0, 2},   // R2: distance 2
        '{1, 1,11, 1,1,10, 1,0, 0,0,0, 5},   // R5: distance 3
        '{1,10,10, 1,1, 1, 1,0, 0,0,0, 5},
        '{1, 1, 1, 1,1, 1, 1,0, 2,2,0, 1},   // R1: both operands
        '{1, 1, 1, 1,1, 5, 1,0, 2,2,0, 1},
        '{1, 3, 1, 1,1, 7, 1,0, 2,2,0, 3},   // R3: both stages match r1
        '{1, 0, 0, 1,1, 0, 1,0, 0,1,0, 2},   // R2: operand b only
        '{1, 0, 0, 1,1, 9, 1,0, 0,0,0, 4},
        '{1, 0, 0, 1,1, 2, 1,0, 0,0,0, 4},   // R4: producer wrote r0
        '{1, 2, 0, 1,0, 3, 1,1, 0,0,0, 4},   // load r3
        '{1, 3, 6, 1,1, 4, 1,0, 2,0,1, 6},   // R6: use on a, stall
        '{1, 3, 6, 1,1, 4, 1,0, 0,0,0, 6},   // R6: held, bubble in EX
        '{1, 7, 3, 1,1, 6, 1,0, 1,0,0, 6},   // R6: consumer gets 2'b01
        '{1, 4, 0, 1,0, 8, 1,1, 0,0,0, 5},   // load r8
        '{1, 1, 8, 1,1, 9, 1,0, 1,0,1, 6},   // R6: use on b, stall
        '{1, 1, 8, 1,1, 9, 1,0, 0,0,0, 6},
        '{1, 8, 0, 1,0, 1, 1,0, 0,1,0, 6},   // R6: b from MEM/WB
        '{1, 5, 0, 1,0, 0, 1,1, 0,0,0, 4},   // load r0
        '{1, 0, 0, 1,1, 2, 1,0, 0,0,0, 4},   // R4: no stall on r0
        '{1, 1, 0, 1,0, 7, 1,1, 0,0,0, 7},   // load r7
        '{1, 2, 7, 1,0, 0, 0,0, 0,0,0, 7},   // R7: unused rs2 = r7
        '{0, 0, 0, 0,0, 5, 1,0, 1,0,0, 7},   // R7: unused b matches EX/MEM
        '{1, 5, 5, 1,1, 6, 1,0, 0,0,0, 8},
        '{1, 5, 5, 1,1, 6, 1,0, 0,0,0, 8},   // R8: invalid slot not a source
        '{0, 0, 0, 0,0, 0, 0,0, 0,0,0, 8}
    };

    task automatic chk(input string what, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", what, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [4:0] rs1, input logic [4:0] rs2,
                         input logic u1, input logic u2, input logic [4:0] rd,
                         input logic we, input logic ld);
        id_valid = v; id_rs1 = rs1; id_rs2 = rs2; id_rs1_used = u1;
        id_rs2_used = u2; id_rd = rd; id_we = we; id_load = ld;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        #2;
        chk("R9 reset a_sel", fwd_a_sel, 0);
        chk("R9 reset b_sel", fwd_b_sel, 0);
        chk("R9 reset stall", stall_front, 0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i].v, VEC[i].rs1, VEC[i].rs2, VEC[i].u1, VEC[i].u2,
                  VEC[i].rd, VEC[i].we, VEC[i].ld);
            #2;
            chk($sformatf("R%0d row %0d a_sel", VEC[i].req, i), fwd_a_sel, VEC[i].ea);
            chk($sformatf("R%0d row %0d b_sel", VEC[i].req, i), fwd_b_sel, VEC[i].eb);
            chk($sformatf("R%0d row %0d stall", VEC[i].req, i), stall_front, VEC[i].es);
            chk($sformatf("R10 row %0d bubble", i), bubble_ex, VEC[i].es);
        end

        // R8: a load in execute next to an invalid slot that names its destination
        @(negedge clk); drive(1, 1, 0, 1, 0, 7, 1, 1);
        @(negedge clk); drive(0, 7, 7, 1, 1, 3, 1, 0);
        #2;
        chk("R8 invalid slot stall", stall_front, 0);
        chk("R10 invalid slot bubble", bubble_ex, 0);

        // R9: reset applied while a load-use stall is pending
        @(negedge clk); drive(1, 1, 0, 1, 0, 7, 1, 1);
        @(negedge clk); drive(1, 7, 0, 1, 0, 3, 1, 0);
        #2;
        chk("R6 stall before reset", stall_front, 1);
        rst_n = 1'b0;
        @(negedge clk);
        #2;
        chk("R9 stall after reset", stall_front, 0);
        chk("R9 a_sel after reset", fwd_a_sel, 0);
        chk("R9 b_sel after reset", fwd_b_sel, 0);
        rst_n = 1'b1;
        @(negedge clk); drive(0, 0, 0, 0, 0, 0, 0, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule